// File: doc/BRIEF.md
# UART Transmit Holding and Shift Stage

This block is the transmit half of a serial port channel. It has two storage stages. A holding register takes one character from the host. A shift register serializes characters onto the line. A ready flag tells the host when the holding register can take a character. The flag drops when a character is written. It comes back only when the shifter takes that character. This means the flag is the inverse of holding-register occupancy.

Each character goes out as an asynchronous frame. The frame has a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts one period of an external bit-rate tick. Loads into the shifter happen only on a tick. Every bit, including the start bit, therefore lasts one full tick period. If the next character is already waiting when a stop bit ends, the next start bit follows with no idle time.

A transmitter-enable input decides whether host writes are taken. Writes made while the block is disabled or not ready are dropped without any effect.

Top module: `uart_tx_pair`

## Requirements
- R1: After reset, txReady is 1, txEmpty is 1 and txLine is 1. Whenever no frame is being shifted, txLine is 1.
- R2: A write (wrValid=1) accepted while txReady=1 and txEnable=1 makes txReady 0 from the next clock.
- R3: While the shifter is idle or at the last tick of a stop bit, a bitTick with a character held moves that character into the shifter. txReady returns to 1 after that edge, so a held character waits at most one tick period.
- R4: A write while txReady=0 is dropped: the held character is unchanged and the dropped value never appears on txLine. This includes a write in the same cycle as a shifter load.
- R5: A write while txEnable=0 is dropped: txReady stays 1 and no frame is sent.
- R6: txEmpty is 1 only when no character is held and the shifter has finished its stop bit.
- R7: A frame on txLine is one 0 start bit, then wrData[0] through wrData[7], then one 1 stop bit. Each bit lasts exactly one bitTick period.
- R8: When a character is held at the end of a stop bit, the next start bit begins on that same tick, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Transmitter enable; host writes are taken only while it is 1 |
| wrValid | input | 1 | Host write strobe, one cycle per character |
| wrData | input | 8 | Character from the host |
| bitTick | input | 1 | One-cycle pulse per bit period |
| txReady | output | 1 | 1 when the holding register can take a character |
| txEmpty | output | 1 | 1 when both stages are empty |
| txLine | output | 1 | Serial output, high when idle |

## Verification
Two events can fall in the same clock: a shifter load on a tick and a host write. The bench keeps wrValid asserted across the load tick. It judges the outcome through the scoreboard. The write driven in the load cycle, while txReady is still 0, must never reach the line. The write in the next cycle, after txReady has risen, must be transmitted. A second case is a stop bit ending while a character is held. The monitor measures the idle gap before the next start bit, and that gap must be zero tick periods.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic captureHold;  // copy host character into holding register
    logic loadShift;    // move holding register into shifter as a frame
    logic shiftBit;     // advance shifter by one bit
  } txStrobe_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txEnable,
  input  logic       wrValid,
  input  logic       bitTick,
  output txStrobe_t  strobe,
  output logic       txReady,
  output logic       txEmpty,
  output logic       busy
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic             holdValid;
  logic [CNT_W-1:0] bitCnt;
  logic             acceptWr;
  logic             frameEnd;
  logic             loadNow;
  logic             shiftNow;

  assign acceptWr = wrValid && txEnable && !holdValid;
  assign frameEnd = busy && bitTick && (bitCnt == LAST_BIT);
  assign loadNow  = bitTick && holdValid && (!busy || frameEnd);
  assign shiftNow = busy && bitTick && !frameEnd;

  assign strobe.captureHold = acceptWr;
  assign strobe.loadShift   = loadNow;
  assign strobe.shiftBit    = shiftNow;

  assign txReady = !holdValid;
  assign txEmpty = !holdValid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdValid <= 1'b0;
      busy      <= 1'b0;
      bitCnt    <= '0;
    end else begin
      if (acceptWr)     holdValid <= 1'b1;
      else if (loadNow) holdValid <= 1'b0;

      if (loadNow) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (frameEnd) begin
        busy   <= 1'b0;
      end else if (shiftNow) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    loadNow |=> (txReady && busy)); // R3
  AST_DISABLED_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!txEnable && txReady) |=> txReady); // R5
  AST_EMPTY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    txEmpty |-> (txReady && !busy)); // R6
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= LAST_BIT); // R7
endmodule

// File: rtl/uart_tx_data.sv
module uart_tx_data
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  txStrobe_t            strobe,
  input  logic [DATA_BITS-1:0] wrData,
  output logic                 serialBit
);
  localparam int FRAME_BITS = DATA_BITS + 2;

  logic [DATA_BITS-1:0]  holdReg;
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (strobe.captureHold) holdReg <= wrData;
      if (strobe.loadShift)
        shiftReg <= {1'b1, holdReg, 1'b0};
      else if (strobe.shiftBit)
        shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end
  end

  assign serialBit = shiftReg[0];

  AST_LOAD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadShift |=> !serialBit); // R7
endmodule

// File: rtl/uart_tx_pair.sv
module uart_tx_pair
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 txEnable,
  input  logic                 wrValid,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 bitTick,
  output logic                 txReady,
  output logic                 txEmpty,
  output logic                 txLine
);
  txStrobe_t strobe;
  logic      busy;
  logic      serialBit;

  uart_tx_ctrl #(.DATA_BITS(DATA_BITS)) ctrl (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .wrValid(wrValid),
    .bitTick(bitTick), .strobe(strobe), .txReady(txReady),
    .txEmpty(txEmpty), .busy(busy)
  );

  uart_tx_data #(.DATA_BITS(DATA_BITS)) data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .serialBit(serialBit)
  );

  assign txLine = busy ? serialBit : 1'b1;

  AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && txEnable && txReady) |=> !txReady); // R2
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    txEmpty |-> txLine); // R1
  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bitTick) |-> $stable(txLine)); // R7
endmodule

// File: tb/tb_uart_tx_pair.sv
module tb_uart_tx_pair;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txEnable = 1'b1;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       bitTick = 1'b0;
  logic       txReady, txEmpty, txLine;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] expQ[$];
  int framesSeen = 0;
  int lastGap = 0;
  logic tickSeen = 1'b0;
  logic done = 1'b0;

  uart_tx_pair dut (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .wrValid(wrValid),
    .wrData(wrData), .bitTick(bitTick), .txReady(txReady),
    .txEmpty(txEmpty), .txLine(txLine)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick generator: one-cycle pulse every TICK_DIV clocks, driven at negedge
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      bitTick = (cnt == TICK_DIV - 1);
      cnt = (cnt + 1) % TICK_DIV;
    end
  end

  always @(posedge clk) tickSeen <= bitTick;

  // monitor: samples the line once per bit after each tick edge
  initial begin
    int bitIdx;
    int gap;
    logic busyFrame;
    logic [7:0] got;
    logic [7:0] exp;
    bitIdx = 0; gap = 0; busyFrame = 1'b0; got = '0;
    forever begin
      @(negedge clk);
      if (rst_n && tickSeen) begin
        if (!busyFrame) begin
          if (txLine == 1'b0) begin
            busyFrame = 1'b1; bitIdx = 0; lastGap = gap;
          end else gap++;
        end else if (bitIdx < 8) begin
          got[bitIdx] = txLine; bitIdx++;
        end else begin
          check(txLine == 1'b1, "R7 stop bit", int'(txLine), 1);
          if (expQ.size() == 0) begin
            check(1'b0, "R4/R5 unexpected frame", int'(got), -1);
          end else begin
            exp = expQ.pop_front();
            check(got == exp, "R7 frame data", int'(got), int'(exp));
          end
          framesSeen++; busyFrame = 1'b0; gap = 0;
        end
      end
    end
  end

  // one-cycle write attempt; pushes expected item when acceptance is predicted
  task automatic tryWrite(input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrData = d;
    if (txReady && txEnable) expQ.push_back(d);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while (!(expQ.size() == 0 && txEmpty) && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int n;
    int f0;
    repeat (3) @(negedge clk);
    check(txReady == 1'b1, "R1 reset txReady", int'(txReady), 1);
    check(txEmpty == 1'b1, "R1 reset txEmpty", int'(txEmpty), 1);
    check(txLine == 1'b1, "R1 reset txLine", int'(txLine), 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(txLine == 1'b1, "R1 idle line", int'(txLine), 1);

    // R2, R3: single write, ready clears then returns within one tick period
    tryWrite(8'hA5);
    check(txReady == 1'b0, "R2 ready after write", int'(txReady), 0);
    n = 0;
    while (!txReady && n < 20) begin @(negedge clk); n++; end
    check(n <= TICK_DIV, "R3 ready returns within tick", n, TICK_DIV);
    check(txEmpty == 1'b0, "R6 not empty while shifting", int'(txEmpty), 0);
    waitIdle();
    repeat (2 * TICK_DIV) @(negedge clk);
    check(txEmpty == 1'b1, "R6 empty after stop", int'(txEmpty), 1);
    check(txLine == 1'b1, "R1 line high after frame", int'(txLine), 1);

    // R5: disabled write ignored
    txEnable = 1'b0;
    f0 = framesSeen;
    tryWrite(8'h3C);
    check(txReady == 1'b1, "R5 ready stays high", int'(txReady), 1);
    repeat (15 * TICK_DIV) @(negedge clk);
    check(framesSeen == f0, "R5 no frame sent", framesSeen, f0);
    txEnable = 1'b1;

    // R4: blocked write, then write held across the load tick
    tryWrite(8'h11);
    tryWrite(8'hEE);              // txReady low: dropped
    @(negedge clk);
    wrValid = 1'b1; wrData = 8'h77;
    n = 0;
    while (n < 50) begin
      if (txReady) begin expQ.push_back(8'h77); break; end
      @(negedge clk); n++;
    end
    @(negedge clk);
    wrValid = 1'b0;
    check(txReady == 1'b0, "R4 write after load taken", int'(txReady), 0);
    waitIdle();
    repeat (2 * TICK_DIV) @(negedge clk);
    check(lastGap == 0, "R8 no idle between held chars", lastGap, 0);

    // R7/R8: stream of patterns, each written as soon as ready
    foreach (expQ[i]) begin end
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h80 : (k == 3) ? 8'h01 : 8'(k * 37 + 5);
      n = 0;
      while (!txReady && n < 200) begin @(negedge clk); n++; end
      tryWrite(v);
    end
    waitIdle();
    repeat (3 * TICK_DIV) @(negedge clk);
    check(lastGap == 0, "R8 streaming gap", lastGap, 0);
    check(expQ.size() == 0, "R7 all frames delivered", expQ.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule